// File: doc/BRIEF.md
# Three-Wire SPI Register Slave

This block lets an external SPI host read and write an 8-bit register space through chip select, a serial clock and one shared data line that changes direction inside the frame. It runs on the chip's system clock. Chip select, serial clock and data are brought in through a synchronizer, and the edges of the serial clock are detected in the system clock domain. The serial clock therefore has to be slow compared with the system clock: each half period must last at least SYNC_STAGES+2 system clock cycles.

The first byte of each frame is a command. It holds the transfer direction, an auto-increment flag and a 6-bit register address. Every byte after it is data. On write frames each data byte becomes a one-cycle write strobe on a simple register bus. On read frames the block issues a one-cycle read strobe, captures the returned byte and shifts it out on the shared line, most significant bit first. Both clock polarities that idle in line with the sampling edge are supported: the clock may idle low or high.

Top module: `spi3_reg_slave`

## Requirements
- R1: While `cs_ni` is high, edges on `sclk_i` and `sdio_i` have no effect: no strobe is issued and `sdio_oe_o` stays low. The same holds out of reset.
- R2: Data is sampled on rising `sclk_i` edges. The first rising edge after `cs_ni` falls carries frame bit 0. This works whether the clock idles low or high.
- R3: In the command byte, frame bit 0 selects the direction (1 = read, 0 = write). Bit 1 is the increment flag. Bits 2..7 are the register address, most significant bit first.
- R4: In a write frame, every complete data byte produces exactly one `reg_we_o` pulse. The pulse carries that byte on `reg_wdata_o`, most significant bit first on the line, and the current address on `reg_addr_o`.
- R5: In a read frame, `reg_re_o` pulses once the command byte is complete. `reg_rdata_i` is taken in that cycle. The byte is then driven on `sdio_o` from frame bit 8 onward, one bit after each falling `sclk_i` edge, most significant bit first, so the host can sample it on the next rising edge.
- R6: With the increment flag at 1, the address steps by one after each data byte and wraps from 63 to 0. With the flag at 0, every data byte uses the command address.
- R7: `sdio_oe_o` is low during the whole command byte and throughout write frames. In a read frame it goes high at the first falling edge of the data phase and drops in the same cycle that `cs_ni` goes high.
- R8: If `cs_ni` rises before a byte is complete, that partial byte is dropped and no strobe is issued for it. The next frame starts again at bit 0.
- R9: In a read frame, each completed data byte triggers a further `reg_re_o` pulse for the next address. A read frame of N data bytes therefore gives N+1 read strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from host |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, output side |
| sdio_oe_o | output | 1 | Output enable for the shared data line |
| reg_addr_o | output | 6 | Register address |
| reg_we_o | output | 1 | Write strobe, one cycle |
| reg_wdata_o | output | 8 | Write data |
| reg_re_o | output | 1 | Read strobe, one cycle |
| reg_rdata_i | input | 8 | Read data, valid in the cycle of `reg_re_o` |

## Verification
A write or read strobe appears SYNC_STAGES+2 system clock edges after the rising serial clock edge that completes a byte. A read bit reaches `sdio_o` SYNC_STAGES+1 edges after the falling serial clock edge. The bench holds each serial clock half period for eight system cycles. It takes read bits just before the next rising edge and collects strobes in a negative-edge monitor. The strobe logs are compared only after the frame has ended, which is always later than the worst-case strobe latency. The output-enable monitor runs on every cycle. Because the enable is released combinationally from chip select, the bench clears its allowance window only after chip select has gone high.

// File: rtl/spi3_pkg.sv
`timescale 1ns/1ps
package spi3_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 6;

  typedef enum logic {PH_CMD, PH_DATA} phase_e;

  typedef struct packed {
    logic              rd;
    logic              inc;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/spi3_sync.sv
`timescale 1ns/1ps
module spi3_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi3_bit_engine.sv
`timescale 1ns/1ps
module spi3_bit_engine
  import spi3_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              sdi_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output phase_e            phase_o
);
  localparam int              CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              done_q;
  phase_e            phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
      phase_q <= PH_CMD;
    end else begin
      done_q <= 1'b0;
      if (!active_i) begin
        // frame ended or aborted: drop any partial byte
        cnt_q   <= '0;
        phase_q <= PH_CMD;
      end else begin
        if (done_q) phase_q <= PH_DATA;
        if (rise_i) begin
          sh_q <= {sh_q[BYTE_W-2:0], sdi_i};
          if (cnt_q == LAST) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign byte_done_o = done_q;
  assign byte_o      = sh_q;
  assign phase_o     = phase_q;

  assert_done_after_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(rise_i));
  assert_done_in_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(active_i));
endmodule

// File: rtl/spi3_reg_slave.sv
`timescale 1ns/1ps
module spi3_reg_slave
  import spi3_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_we_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_re_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  logic [2:0] sync_q;
  logic       cs_s, sclk_s, sdi_s, sclk_prev_q;
  logic       active, rise, fall;

  spi3_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sclk_i, sdio_i}),
    .q_o    (sync_q)
  );

  assign {cs_s, sclk_s, sdi_s} = sync_q;
  assign active = ~cs_s;
  assign rise   = active &  sclk_s & ~sclk_prev_q;
  assign fall   = active & ~sclk_s &  sclk_prev_q;

  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  phase_e            phase;
  cmd_t              cmd;

  spi3_bit_engine u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .rise_i      (rise),
    .sdi_i       (sdi_s),
    .byte_done_o (byte_done),
    .byte_o      (byte_val),
    .phase_o     (phase)
  );

  assign cmd = cmd_t'(byte_val);

  logic              rd_q, inc_q, we_q, re_q, drive_q, sdo_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q, tx_q;
  logic              cmd_done, data_done;

  assign cmd_done  = byte_done && (phase == PH_CMD);
  assign data_done = byte_done && (phase == PH_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      rd_q        <= 1'b0;
      inc_q       <= 1'b0;
      we_q        <= 1'b0;
      re_q        <= 1'b0;
      drive_q     <= 1'b0;
      sdo_q       <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      tx_q        <= '0;
    end else begin
      sclk_prev_q <= sclk_s;
      we_q        <= 1'b0;
      re_q        <= 1'b0;
      // write address steps after its strobe, read address before the prefetch
      if (cmd_done)                      addr_q <= cmd.addr;
      else if (we_q && inc_q)            addr_q <= addr_q + 1'b1;
      else if (data_done && rd_q && inc_q) addr_q <= addr_q + 1'b1;
      if (!active) begin
        rd_q    <= 1'b0;
        inc_q   <= 1'b0;
        drive_q <= 1'b0;
      end else begin
        if (cmd_done) begin
          rd_q  <= cmd.rd;
          inc_q <= cmd.inc;
          re_q  <= cmd.rd;
        end else if (data_done) begin
          if (rd_q) re_q <= 1'b1;
          else begin
            we_q    <= 1'b1;
            wdata_q <= byte_val;
          end
        end
        if (re_q) tx_q <= reg_rdata_i;
        else if (fall && rd_q && phase == PH_DATA) begin
          drive_q <= 1'b1;
          sdo_q   <= tx_q[BYTE_W-1];
          tx_q    <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdio_o      = sdo_q;
  assign sdio_oe_o   = drive_q & ~cs_ni;
  assign reg_addr_o  = addr_q;
  assign reg_we_o    = we_q;
  assign reg_wdata_o = wdata_q;
  assign reg_re_o    = re_q;

  assert_no_drive_in_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_q |-> phase == PH_DATA);
  assert_drive_read_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_q |-> rd_q);
  assert_we_write_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !rd_q);
  assert_strobe_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
  assert_re_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);
  assert_addr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && inc_q) |=> reg_addr_o == $past(reg_addr_o) + 1'b1);
  assert_addr_fixed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && !inc_q) |=> $stable(reg_addr_o));
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_s) && cs_s |-> !reg_we_o && !reg_re_o);
endmodule

// File: tb/spi3_reg_slave_test.sv
`timescale 1ns/1ps
module spi3_reg_slave_test;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic       sdo, sdo_oe, we, re;
  logic [5:0] addr;
  logic [7:0] wdata, rdata;

  logic [7:0] resp_mem [64];
  logic [7:0] exp_mem  [64];
  logic [7:0] tx_bytes [8];
  logic [7:0] rx_bytes [8];
  logic [5:0] wr_addr  [64];
  logic [7:0] wr_data  [64];
  logic [5:0] re_addr  [64];
  int wr_n, re_n, oe_bad, oe_missing;
  bit oe_allowed;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  spi3_reg_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdio_i(sdi),
    .sdio_o(sdo), .sdio_oe_o(sdo_oe), .reg_addr_o(addr), .reg_we_o(we),
    .reg_wdata_o(wdata), .reg_re_o(re), .reg_rdata_i(rdata)
  );

  assign rdata = resp_mem[addr];

  always @(negedge clk) begin
    if (we) begin
      if (wr_n < 64) begin wr_addr[wr_n] = addr; wr_data[wr_n] = wdata; end
      wr_n++;
      resp_mem[addr] = wdata;
    end
    if (re) begin
      if (re_n < 64) re_addr[re_n] = addr;
      re_n++;
    end
    if (sdo_oe && !oe_allowed) oe_bad++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic logic [5:0] addr_at(input logic [5:0] a, input bit inc, input int k);
    return inc ? 6'(a + 6'(k)) : a;
  endfunction

  task automatic clear_logs();
    wr_n = 0; re_n = 0; oe_bad = 0; oe_missing = 0;
  endtask

  // full frames plus an optional partial data byte (abort)
  task automatic frame(input bit mode3, input bit rd, input bit inc, input logic [5:0] a,
                       input int nbytes, input int extra_bits);
    logic [7:0] cmd;
    int total;
    cmd = {rd, inc, a};
    total = 8 + 8 * nbytes + extra_bits;
    clear_logs();
    oe_allowed = 0;
    sclk = mode3; cyc(HALF);
    cs_n = 1'b0; cyc(HALF);
    for (int b = 0; b < total; b++) begin
      sclk = 1'b0;
      sdi = (b < 8) ? cmd[7-b] : tx_bytes[(b-8)/8][7-((b-8)%8)];
      if (rd && b >= 8) oe_allowed = 1;
      cyc(HALF);
      if (rd && b >= 8) begin
        rx_bytes[(b-8)/8][7-((b-8)%8)] = sdo;
        if (!sdo_oe) oe_missing++;
      end
      sclk = 1'b1; cyc(HALF);
    end
    cs_n = 1'b1; cyc(1);
    if (!mode3) sclk = 1'b0;
    cyc(2);
    oe_allowed = 0;
    cyc(HALF);
  endtask

  task automatic check_write(input string tag, input logic [5:0] a, input bit inc, input int nbytes);
    chk(wr_n == nbytes, tag, "write strobe count", wr_n, nbytes);
    for (int k = 0; k < nbytes && k < wr_n; k++) begin
      chk(wr_addr[k] == addr_at(a, inc, k), tag, "write address", wr_addr[k], addr_at(a, inc, k));
      chk(wr_data[k] == tx_bytes[k], tag, "write data", wr_data[k], tx_bytes[k]);
      exp_mem[addr_at(a, inc, k)] = tx_bytes[k];
    end
    chk(re_n == 0, "R4", "no read strobe in write frame", re_n, 0);
    chk(oe_bad == 0, "R7", "output enable in write frame", oe_bad, 0);
  endtask

  task automatic check_read(input string tag, input logic [5:0] a, input bit inc, input int nbytes);
    chk(re_n == nbytes + 1, "R9", "read strobe count", re_n, nbytes + 1);
    for (int k = 0; k <= nbytes && k < re_n; k++)
      chk(re_addr[k] == addr_at(a, inc, k), tag, "read address", re_addr[k], addr_at(a, inc, k));
    for (int k = 0; k < nbytes; k++)
      chk(rx_bytes[k] == exp_mem[addr_at(a, inc, k)], "R5", "read data", rx_bytes[k],
          exp_mem[addr_at(a, inc, k)]);
    chk(wr_n == 0, "R5", "no write strobe in read frame", wr_n, 0);
    chk(oe_missing == 0, "R7", "output enable during read data", oe_missing, 0);
    chk(oe_bad == 0, "R7", "output enable outside read data", oe_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 64; i++) begin
      resp_mem[i] = 8'($urandom);
      exp_mem[i]  = resp_mem[i];
    end
    clear_logs();
    oe_allowed = 0;
    cyc(5);
    // R1: reset state
    chk(!sdo_oe && !we && !re, "R1", "reset outputs", {sdo_oe, we, re}, 0);
    rst_n = 1'b1; cyc(4);
    // R1: activity with chip select high
    for (int i = 0; i < 40; i++) begin
      sclk = ~sclk; sdi = 1'($urandom); cyc(HALF);
    end
    sclk = 1'b0; cyc(HALF);
    chk(wr_n == 0 && re_n == 0, "R1", "strobes while deselected", wr_n + re_n, 0);
    chk(oe_bad == 0, "R1", "output enable while deselected", oe_bad, 0);

    // R2/R3/R4: single write, clock idle low
    tx_bytes[0] = 8'hA5;
    frame(1'b0, 1'b0, 1'b0, 6'h10, 1, 0);
    check_write("R3", 6'h10, 1'b0, 1);
    // R2/R5: single read, clock idle high
    frame(1'b1, 1'b1, 1'b0, 6'h10, 1, 0);
    check_read("R2", 6'h10, 1'b0, 1);
    // R6: incrementing write burst wraps 63 -> 0
    tx_bytes[0] = 8'h11; tx_bytes[1] = 8'h22; tx_bytes[2] = 8'h33;
    frame(1'b1, 1'b0, 1'b1, 6'd62, 3, 0);
    check_write("R6", 6'd62, 1'b1, 3);
    // R6: fixed-address write burst
    tx_bytes[0] = 8'h5A; tx_bytes[1] = 8'hC3; tx_bytes[2] = 8'h0F;
    frame(1'b0, 1'b0, 1'b0, 6'd5, 3, 0);
    check_write("R6", 6'd5, 1'b0, 3);
    // R6/R9: incrementing read burst across the wrap
    frame(1'b0, 1'b1, 1'b1, 6'd62, 3, 0);
    check_read("R6", 6'd62, 1'b1, 3);
    // R6: fixed-address read burst
    frame(1'b1, 1'b1, 1'b0, 6'd5, 2, 0);
    check_read("R6", 6'd5, 1'b0, 2);
    // R8: abort after one full byte and five bits
    tx_bytes[0] = 8'h77; tx_bytes[1] = 8'hEE;
    frame(1'b0, 1'b0, 1'b1, 6'd7, 1, 5);
    check_write("R8", 6'd7, 1'b1, 1);
    // R8: abort inside the command byte, then a clean frame decodes from bit 0
    frame(1'b1, 1'b0, 1'b0, 6'd9, 0, 0);
    chk(wr_n == 0, "R8", "strobe after command-only frame", wr_n, 0);
    clear_logs();
    cs_n = 1'b0; cyc(HALF);
    for (int b = 0; b < 4; b++) begin
      sclk = 1'b0; sdi = 1'b1; cyc(HALF); sclk = 1'b1; cyc(HALF);
    end
    cs_n = 1'b1; cyc(HALF * 2);
    chk(wr_n == 0 && re_n == 0, "R8", "strobe after partial command", wr_n + re_n, 0);
    tx_bytes[0] = 8'h3C;
    frame(1'b1, 1'b0, 1'b0, 6'd9, 1, 0);
    check_write("R8", 6'd9, 1'b0, 1);

    // random frames
    for (int n = 0; n < 24; n++) begin
      bit m3, rdr, inc;
      logic [5:0] a;
      int nb;
      m3 = 1'($urandom); rdr = 1'($urandom); inc = 1'($urandom);
      a = 6'($urandom); nb = 1 + int'($urandom % 4);
      for (int k = 0; k < 8; k++) tx_bytes[k] = 8'($urandom);
      frame(m3, rdr, inc, a, nb, 0);
      if (rdr) check_read("R5", a, inc, nb);
      else     check_write("R4", a, inc, nb);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule